// File: doc/BRIEF.md
# Fan PWM Speed Controller with Soft Start

This block generates the per-cycle switch enables for a single-phase fan output stage. A free-running digital triangle carrier sweeps between two fixed codes. On every clock the carrier is compared against one threshold, which is built from three codes on the same 8-bit unsigned scale. The first is a speed command, where a higher code means less drive. The second is a minimum-speed code that acts as a floor on duty. The third is a soft-start ramp that opens slowly after reset. The upper switch is enabled only while the carrier lies above the threshold. The lower switch stays enabled whenever the motor is meant to run, so coil current recirculates through it during the off part of each carrier cycle.

A current-sense flag cuts the upper switch at once. The cut holds until the carrier returns to its low point, so one noisy sample can never chop the drive into fragments within a cycle. The block also reports how many carrier steps per period the upper switch is on, so neighbouring logic can watch the effective duty. A clock prescaler sets the carrier rate, and a second setting sets how many carrier periods pass between soft-start steps.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: While rst_n is low, hi_en and lo_en are 0, duty_ticks is 0 and carrier equals CAR_LO.
- R2: carrier moves by one code every prescale+1 clocks. It runs up from CAR_LO to CAR_HI and back down, and never leaves that range. One full period therefore lasts 2*(CAR_HI-CAR_LO)*(prescale+1) clocks.
- R3: The threshold is max(min(speed_cmd, min_cmd), ramp). For CAR_LO < threshold < CAR_HI, hi_en is 1 in the cycle after each carrier value strictly above the threshold. That gives 2*(CAR_HI-threshold)-1 on-steps per period.
- R4: A threshold at or below CAR_LO holds hi_en at 1 on every cycle (full speed).
- R5: A threshold at or above CAR_HI holds both hi_en and lo_en at 0 (stop). This includes min_cmd = 255 with speed_cmd at or above CAR_HI.
- R6: min_cmd is a floor on duty. When speed_cmd asks for less drive than min_cmd, min_cmd sets the threshold.
- R7: While the threshold is below CAR_HI, lo_en is 1 on every cycle, including the cycles in which hi_en is 0.
- R8: A high cl_flag forces hi_en to 0 from the next cycle. It stays 0 until the carrier has passed its low point, and hi_en returns two cycles after the sample in which carrier equals CAR_LO. lo_en is not affected.
- R9: After reset the ramp starts at CAR_HI. It falls by one code every ss_period+1 carrier periods and stops at CAR_LO. With fixed commands, duty never falls during the ramp.
- R10: duty_ticks gives the upper on-steps per carrier period for the current threshold, one cycle after the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_cmd | input | 8 | Speed command code, higher means slower |
| min_cmd | input | 8 | Minimum-speed floor code, 255 disables the floor |
| prescale | input | PRE_W | Carrier step every prescale+1 clocks |
| ss_period | input | SS_W | Soft-start step every ss_period+1 carrier periods |
| cl_flag | input | 1 | Current-sense over-limit flag |
| hi_en | output | 1 | Upper switch enable |
| lo_en | output | 1 | Lower switch enable |
| carrier | output | 8 | Present carrier code |
| duty_ticks | output | 9 | Upper on-steps per carrier period |

## Verification
The assertions assume that CAR_HI exceeds CAR_LO by at least two. They also assume that cl_flag and the command codes are synchronous to clk. They make no assumption about how long cl_flag stays high or when it rises within the carrier cycle. The stimulus changes inputs only on falling clock edges. It keeps prescale and ss_period fixed between resets, so the carrier and the ramp step counters never see a limit change partway through a count. Current-limit pulses are placed on the rising half of the carrier, so the release at the low point can be seen separately from the pulse.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CODE_W:0]   ticks_t;

  // Threshold: floor the command by the minimum-speed code, cap by the ramp (R3, R6, R9)
  function automatic code_t pick_thr(code_t spd, code_t floor_c, code_t ramp);
    code_t lower;
    lower = (spd < floor_c) ? spd : floor_c;
    return (ramp > lower) ? ramp : lower;
  endfunction

  // Upper drive decision for one carrier sample (R3, R4, R5)
  function automatic logic upper_on(code_t c, code_t e, code_t lo, code_t hi);
    if (e <= lo)      return 1'b1;
    else if (e >= hi) return 1'b0;
    else              return c > e;
  endfunction

  // On-steps per carrier period for a threshold (R10)
  function automatic ticks_t on_ticks(code_t e, code_t lo, code_t hi);
    if (e <= lo)      return ticks_t'((int'(hi) - int'(lo)) * 2);
    else if (e >= hi) return '0;
    else              return ticks_t'((int'(hi) - int'(e)) * 2 - 1);
  endfunction
endpackage

// File: rtl/fpc_carrier.sv
module fpc_carrier
  import fan_pwm_pkg::*;
#(
  parameter code_t LO    = 8'd16,
  parameter code_t HI    = 8'd240,
  parameter int    PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  output code_t            car,
  output logic             wrap
);
  logic [PRE_W-1:0] pre_q;
  logic             up_q;
  logic             tick;

  assign tick = (pre_q == prescale);
  // one pulse per period, at the low turning point (R2, R8, R9)
  assign wrap = tick & ~up_q & (car == LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      car   <= LO;
      up_q  <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (up_q) begin
          if (car == HI) begin
            car  <= HI - code_t'(1);
            up_q <= 1'b0;
          end else begin
            car <= car + code_t'(1);
          end
        end else begin
          if (car == LO) begin
            car  <= LO + code_t'(1);
            up_q <= 1'b1;
          end else begin
            car <= car - code_t'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpc_softstart.sv
module fpc_softstart
  import fan_pwm_pkg::*;
#(
  parameter code_t LO   = 8'd16,
  parameter code_t HI   = 8'd240,
  parameter int    SS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  input  logic [SS_W-1:0] ss_period,
  output code_t           ramp
);
  logic [SS_W-1:0] step_q;

  // R9: ramp opens one code every ss_period+1 carrier periods
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp   <= HI;
      step_q <= '0;
    end else if (wrap) begin
      if (step_q == ss_period) begin
        step_q <= '0;
        if (ramp > LO) ramp <= ramp - code_t'(1);
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpc_climit.sv
module fpc_climit (
  input  logic clk,
  input  logic rst_n,
  input  logic cl_flag,
  input  logic wrap,
  output logic lim,
  output logic cut
);
  // R8: hold the cut until the carrier reaches its low point
  always_ff @(posedge clk) begin
    if (!rst_n) lim <= 1'b0;
    else        lim <= wrap ? cl_flag : (lim | cl_flag);
  end

  assign cut = lim | cl_flag;
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter code_t CAR_LO = 8'd16,
  parameter code_t CAR_HI = 8'd240,
  parameter int    PRE_W  = 8,
  parameter int    SS_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       speed_cmd,
  input  logic [7:0]       min_cmd,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SS_W-1:0]  ss_period,
  input  logic             cl_flag,
  output logic             hi_en,
  output logic             lo_en,
  output logic [7:0]       carrier,
  output logic [8:0]       duty_ticks
);
  code_t  car_w;
  code_t  ramp_w;
  code_t  thr_w;
  logic   wrap_w;
  logic   lim_w;
  logic   cut_w;
  logic   drive_w;
  logic   run_w;
  ticks_t ticks_w;

  fpc_carrier #(.LO(CAR_LO), .HI(CAR_HI), .PRE_W(PRE_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .car(car_w), .wrap(wrap_w)
  );

  fpc_softstart #(.LO(CAR_LO), .HI(CAR_HI), .SS_W(SS_W)) u_soft (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .ss_period(ss_period), .ramp(ramp_w)
  );

  fpc_climit u_lim (
    .clk(clk), .rst_n(rst_n), .cl_flag(cl_flag), .wrap(wrap_w), .lim(lim_w), .cut(cut_w)
  );

  assign thr_w   = pick_thr(speed_cmd, min_cmd, ramp_w);
  assign drive_w = upper_on(car_w, thr_w, CAR_LO, CAR_HI);
  assign run_w   = thr_w < CAR_HI;
  assign ticks_w = on_ticks(thr_w, CAR_LO, CAR_HI);

  // R1, R3, R7, R10: registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_en      <= 1'b0;
      lo_en      <= 1'b0;
      duty_ticks <= '0;
    end else begin
      hi_en      <= drive_w & ~cut_w;
      lo_en      <= run_w;
      duty_ticks <= ticks_w;
    end
  end

  assign carrier = car_w;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import fan_pwm_pkg::*;
#(
  parameter code_t LO = 8'd16,
  parameter code_t HI = 8'd240
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cl_flag,
  input logic       hi_en,
  input logic       lo_en,
  input logic [7:0] carrier,
  input logic [8:0] duty_ticks,
  input code_t      ramp,
  input logic       lim,
  input logic       wrap
);
  a_r7_upper_needs_lower: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |-> lo_en);

  a_r8_cut_next: assert property (@(posedge clk) disable iff (!rst_n)
    cl_flag |=> !hi_en);

  a_r8_latched_cut: assert property (@(posedge clk) disable iff (!rst_n)
    lim |=> !hi_en);

  a_r8_release_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cl_flag) |=> !lim);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier >= LO) && (carrier <= HI));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier != $past(carrier)) |->
      ((carrier == code_t'($past(carrier) + 8'd1)) || (carrier == code_t'($past(carrier) - 8'd1))));

  a_r9_ramp_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ramp <= $past(ramp));

  a_r9_ramp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ramp >= LO);

  a_r5_zero_duty_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_ticks == 9'd0) |-> !hi_en);
endmodule

bind fan_pwm_ctrl fpc_checker #(.LO(CAR_LO), .HI(CAR_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cl_flag(cl_flag), .hi_en(hi_en), .lo_en(lo_en),
  .carrier(carrier), .duty_ticks(duty_ticks), .ramp(ramp_w), .lim(lim_w), .wrap(wrap_w)
);

// File: tb/fan_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module fan_pwm_ctrl_bench;
  localparam int LO  = 4;
  localparam int HI  = 20;
  localparam int PER = 2 * (HI - LO);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] speed_cmd = 8'd0;
  logic [7:0] min_cmd = 8'd255;
  logic [7:0] prescale = 8'd0;
  logic [7:0] ss_period = 8'd0;
  logic       cl_flag = 1'b0;
  logic       hi_en, lo_en;
  logic [7:0] carrier;
  logic [8:0] duty_ticks;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fan_pwm_ctrl #(.CAR_LO(8'(LO)), .CAR_HI(8'(HI)), .PRE_W(8), .SS_W(8)) u_fan_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .speed_cmd(speed_cmd), .min_cmd(min_cmd),
    .prescale(prescale), .ss_period(ss_period), .cl_flag(cl_flag),
    .hi_en(hi_en), .lo_en(lo_en), .carrier(carrier), .duty_ticks(duty_ticks)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model: walk one carrier period and count samples above threshold
  function automatic int exp_on(input int spd, input int mn);
    int e, n;
    e = (spd < mn) ? spd : mn;
    if (e < LO) e = LO;
    n = 0;
    for (int i = 0; i < PER; i++) begin
      int c;
      c = (i <= HI - LO) ? LO + i : 2 * HI - LO - i;
      if (e <= LO) n++;
      else if (e < HI && c > e) n++;
    end
    return n;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input int spd, input int mn, input int ssp, input int pre);
    @(negedge clk);
    rst_n = 1'b0; speed_cmd = 8'(spd); min_cmd = 8'(mn);
    ss_period = 8'(ssp); prescale = 8'(pre); cl_flag = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  // reset, then wait out the soft start (ss_period 0: one step per period)
  task automatic settle(input int spd, input int mn);
    do_reset(spd, mn, 0, 0);
    cyc((HI - LO) * PER + 2 * PER);
  endtask

  task automatic win(output int hi_n, output int lo_n);
    hi_n = 0; lo_n = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (hi_en) hi_n++;
      if (lo_en) lo_n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    chk(hi_en == 1'b0, "R1 hi_en in reset", hi_en, 0);
    chk(lo_en == 1'b0, "R1 lo_en in reset", lo_en, 0);
    chk(duty_ticks == 9'd0, "R1 duty_ticks in reset", duty_ticks, 0);
    chk(carrier == 8'(LO), "R1 carrier in reset", carrier, LO);
  endtask

  task automatic t_prescale();
    int t0, t1, n, prev;
    bit bad;
    do_reset(0, 255, 0, 3);
    prev = carrier; t0 = -1; t1 = -1; n = 0; bad = 0;
    while (t1 < 0 && n < 2000) begin
      @(negedge clk); n++;
      if (carrier < LO || carrier > HI) bad = 1;
      if (prev == LO && carrier == LO + 1) begin
        if (t0 < 0) t0 = n; else t1 = n;
      end
      prev = carrier;
    end
    chk(t1 - t0 == PER * 4, "R2 carrier period with prescale 3", t1 - t0, PER * 4);
    chk(!bad, "R2 carrier stays in range", bad, 0);
  endtask

  task automatic t_level(input int spd, input int mn, input string req);
    int h, l, e;
    settle(spd, mn);
    e = exp_on(spd, mn);
    chk(duty_ticks == 9'(e), {req, " duty_ticks"}, duty_ticks, e);
    win(h, l);
    chk(h == e, {req, " upper on-count per period"}, h, e);
    chk(l == ((e > 0) ? PER : 0), {req, " R7 lower on-count"}, l, (e > 0) ? PER : 0);
  endtask

  task automatic t_live_change();
    int h, l, e;
    settle(0, 255);
    @(negedge clk); speed_cmd = 8'd9;
    cyc(2);
    e = exp_on(9, 255);
    chk(duty_ticks == 9'(e), "R10 duty_ticks after command change", duty_ticks, e);
    win(h, l);
    chk(h == e, "R3 on-count after command change", h, e);
  endtask

  task automatic t_climit();
    int hi_seen, n;
    settle(0, 255);
    while (!(carrier == 8'((LO + HI) / 2) && hi_en)) @(negedge clk);
    cl_flag = 1'b1;
    @(negedge clk);
    cl_flag = 1'b0;
    chk(hi_en == 1'b0, "R8 upper cut next cycle", hi_en, 0);
    hi_seen = 0; n = 0;
    while (carrier != 8'(LO) && n < 200) begin
      @(negedge clk); n++;
      if (hi_en) hi_seen++;
      chk(lo_en == 1'b1, "R8 lower unaffected", lo_en, 1);
    end
    chk(hi_seen == 0, "R8 upper held off until low point", hi_seen, 0);
    @(negedge clk);
    chk(hi_en == 1'b0, "R8 still off one cycle after low point", hi_en, 0);
    @(negedge clk);
    chk(hi_en == 1'b1, "R8 released after low point", hi_en, 1);
  endtask

  task automatic t_softstart();
    int h, l, prev, drops;
    do_reset(0, 255, 1, 0);
    win(h, l);
    chk(h == 0, "R9 no upper drive in first period", h, 0);
    chk(duty_ticks == 9'd0, "R9 duty zero at start", duty_ticks, 0);
    prev = duty_ticks; drops = 0;
    for (int i = 0; i < 600 - PER; i++) begin
      @(negedge clk);
      if (int'(duty_ticks) < prev) drops++;
      prev = duty_ticks;
    end
    chk(duty_ticks > 0 && duty_ticks < 9'(PER), "R9 duty partway at cycle 600", duty_ticks, 17);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (int'(duty_ticks) < prev) drops++;
      prev = duty_ticks;
    end
    chk(duty_ticks < 9'(PER), "R9 ramp not finished at cycle 900", duty_ticks, 27);
    cyc(300);
    chk(duty_ticks == 9'(PER), "R9 full duty after ramp", duty_ticks, PER);
    chk(drops == 0, "R9 duty never falls", drops, 0);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_level(0, 255, "R4 command 0");
    t_level(LO, 255, "R4 command at low limit");
    t_level(5, 255, "R3 command 5");
    t_level(12, 255, "R3 command 12");
    t_level(HI, 255, "R5 command at high limit");
    t_level(25, 255, "R5 stop with floor unused");
    t_level(30, 10, "R6 floor sets duty");
    t_level(6, 10, "R6 command above floor");
    t_live_change();
    t_climit();
    t_softstart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule